// File: doc/BRIEF.md
# Privilege-Aware Page Access Checker

This block sits directly after a page-table lookup and decides whether a memory access may go ahead. It takes the privilege level of the current access, the translation-mode field of the translation control register, the matching page entry word and three access strobes (read, write, execute). From these it produces a translation-enable flag, a combinational grant, and a one-cycle fault pulse with a cause code that is registered on the clock edge after a denied access.

Translation applies only when the mode field selects one of the two paged schemes and the access does not come from machine level. Otherwise the block treats the address as physical and grants the access without inspecting the page entry. When translation applies, the entry must be present, and a page that is not marked user-accessible may only be touched from supervisor level. A caller may express privilege directly or as a ring number, where rings below 3 count as supervisor.

Top module: `page_access_checker`

## Requirements
- R1: `xlate_en_o` is 1 exactly when `mode_i` equals 8 or 9 and the access is not at machine level (`priv_i` = 2'b11); `mode_i` = 0 selects bare addressing.
- R2: At machine level `xlate_en_o` is 0 and any strobed access is granted, whatever `mode_i` and `pte_i` hold.
- R3: A reserved `mode_i` value (anything other than 0, 8 or 9) behaves as bare: `xlate_en_o` is 0, any strobed access is granted and `fault_o` stays 0.
- R4: With translation on and the entry present, an entry with the user bit (`pte_i[2]`) set is granted at user and supervisor level alike.
- R5: With translation on and the entry present, an entry with `pte_i[2]` clear is granted at supervisor level (`priv_i` = 2'b01) and denied at user level (`priv_i` = 2'b00).
- R6: With `priv_i` = 2'b10 the level comes from `ring_i`: rings 0, 1 and 2 act as supervisor, ring 3 acts as user.
- R7: With translation on, an entry whose present bit (`pte_i[0]`) is clear is denied, and the cause is not-present (2'b10) even when the privilege check would also fail.
- R8: `grant_o` is combinational in the same cycle as the strobe and is 0 whenever none of `rd_i`, `wr_i`, `ex_i` is high.
- R9: `fault_o` is 1 for exactly the cycle after a strobed access that was denied, with `cause_o` = 2'b01 for a privilege violation; in every other cycle, and after reset, `fault_o` is 0 and `cause_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Privilege: 00 user, 01 supervisor, 10 ring-numbered, 11 machine |
| ring_i | input | 2 | Ring number used when `priv_i` is 10 |
| mode_i | input | 4 | Translation mode field |
| pte_i | input | 64 | Matching page entry word |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ex_i | input | 1 | Execute strobe |
| xlate_en_o | output | 1 | Address goes through page translation |
| grant_o | output | 1 | Access may proceed |
| fault_o | output | 1 | Registered fault pulse |
| cause_o | output | 2 | Fault cause: 00 none, 01 privilege, 10 not present |

## Verification
The bench drives machine level with a supervisor-only, non-present entry under a paged mode; a design that let the mode field reach machine accesses would deny and raise a fault. It sweeps reserved mode codes with a bad entry, which catches a decoder that treats only zero as bare. It presents a non-present, supervisor-only entry to user code, where a design with the priority reversed reports cause 01 instead of 10, and it walks all four ring numbers, where an off-by-one ring comparison flips ring 2 or ring 3. Back-to-back denied and granted strobes show whether the fault pulse lasts longer than one cycle or lingers with a stale cause.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    PRIV_USER = 2'b00,
    PRIV_SUP  = 2'b01,
    PRIV_RING = 2'b10,
    PRIV_MACH = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_PRIV    = 2'b01,
    CAUSE_ABSENT  = 2'b10,
    CAUSE_UNUSED  = 2'b11
  } cause_e;
endpackage

// File: rtl/pac_priv_decode.sv
module pac_priv_decode #(
  parameter int RING_W    = 2,
  parameter int USER_RING = 3
) (
  input  logic [1:0]        priv_i,
  input  logic [RING_W-1:0] ring_i,
  output logic              is_mach_o,
  output logic              is_sup_o
);
  import pac_pkg::*;

  always_comb begin
    is_mach_o = (priv_i == PRIV_MACH);
    unique case (priv_i)
      PRIV_SUP:  is_sup_o = 1'b1;
      PRIV_RING: is_sup_o = (ring_i < RING_W'(USER_RING));
      PRIV_MACH: is_sup_o = 1'b1;
      default:   is_sup_o = 1'b0;
    endcase
  end

  // R6: ring-numbered privilege at the top ring is user level
  always_comb begin
    if (priv_i == PRIV_RING && ring_i == RING_W'(USER_RING))
      p_top_ring_user_r6: assert (!is_sup_o);
  end
endmodule

// File: rtl/pac_mode_decode.sv
module pac_mode_decode #(
  parameter int MODE_W     = 4,
  parameter int MODE_BARE  = 0,
  parameter int MODE_PG_A  = 8,
  parameter int MODE_PG_B  = 9
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              is_mach_i,
  output logic              xlate_en_o,
  output logic              reserved_o
);
  localparam int NUM_PG = 2;
  localparam logic [MODE_W-1:0] PG_CODES [NUM_PG] =
    '{MODE_W'(MODE_PG_A), MODE_W'(MODE_PG_B)};

  logic [NUM_PG-1:0] pg_hit;
  logic              bare_hit;

  for (genvar g = 0; g < NUM_PG; g++) begin : g_pg
    assign pg_hit[g] = (mode_i == PG_CODES[g]);
  end

  assign bare_hit   = (mode_i == MODE_W'(MODE_BARE));
  assign reserved_o = !bare_hit && !(|pg_hit);
  // reserved codes fall back to bare; machine level never translates
  assign xlate_en_o = (|pg_hit) && !is_mach_i;

  always_comb begin
    p_mach_bypass_r2: assert (!(is_mach_i && xlate_en_o));
    p_reserved_bare_r3: assert (!(reserved_o && xlate_en_o));
  end
endmodule

// File: rtl/pac_perm_check.sv
module pac_perm_check (
  input  logic       xlate_en_i,
  input  logic       is_sup_i,
  input  logic       present_i,
  input  logic       user_ok_i,
  input  logic       req_i,
  output logic       grant_o,
  output logic       denied_o,
  output logic [1:0] cause_o
);
  import pac_pkg::*;

  logic allow;

  always_comb begin
    cause_o = CAUSE_NONE;
    allow   = 1'b1;
    if (xlate_en_i) begin
      if (!present_i) begin
        allow   = 1'b0;
        cause_o = CAUSE_ABSENT;   // takes priority over privilege
      end else if (!user_ok_i && !is_sup_i) begin
        allow   = 1'b0;
        cause_o = CAUSE_PRIV;
      end
    end
  end

  assign grant_o  = req_i && allow;
  assign denied_o = req_i && !allow;

  always_comb begin
    p_grant_needs_req_r8: assert (!(grant_o && !req_i));
    p_bypass_grants_r2: assert (!(req_i && !xlate_en_i && !grant_o));
  end
endmodule

// File: rtl/pac_fault_reg.sv
module pac_fault_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       denied_i,
  input  logic [1:0] cause_i,
  output logic       fault_o,
  output logic [1:0] cause_o
);
  import pac_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      cause_o <= CAUSE_NONE;
    end else begin
      fault_o <= denied_i;
      cause_o <= denied_i ? cause_i : CAUSE_NONE;
    end
  end

  p_fault_follows_deny_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    denied_i |=> fault_o);
  p_no_spurious_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !denied_i |=> (!fault_o && cause_o == CAUSE_NONE));
  p_cause_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o != CAUSE_UNUSED);
endmodule

// File: rtl/page_access_checker.sv
module page_access_checker #(
  parameter int PTE_W       = 64,
  parameter int MODE_W      = 4,
  parameter int RING_W      = 2,
  parameter int USER_RING   = 3,
  parameter int PRESENT_BIT = 0,
  parameter int USER_BIT    = 2,
  parameter int MODE_BARE   = 0,
  parameter int MODE_PG_A   = 8,
  parameter int MODE_PG_B   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        priv_i,
  input  logic [RING_W-1:0] ring_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [PTE_W-1:0]  pte_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              ex_i,
  output logic              xlate_en_o,
  output logic              grant_o,
  output logic              fault_o,
  output logic [1:0]        cause_o
);
  import pac_pkg::*;

  logic       is_mach, is_sup, reserved, req, denied;
  logic [1:0] cause_c;
  logic       unused_pte;

  assign req        = rd_i | wr_i | ex_i;
  assign unused_pte = ^pte_i;

  pac_priv_decode #(.RING_W(RING_W), .USER_RING(USER_RING)) u_priv (
    .priv_i   (priv_i),
    .ring_i   (ring_i),
    .is_mach_o(is_mach),
    .is_sup_o (is_sup)
  );

  pac_mode_decode #(
    .MODE_W(MODE_W), .MODE_BARE(MODE_BARE),
    .MODE_PG_A(MODE_PG_A), .MODE_PG_B(MODE_PG_B)
  ) u_mode (
    .mode_i    (mode_i),
    .is_mach_i (is_mach),
    .xlate_en_o(xlate_en_o),
    .reserved_o(reserved)
  );

  pac_perm_check u_perm (
    .xlate_en_i(xlate_en_o),
    .is_sup_i  (is_sup),
    .present_i (pte_i[PRESENT_BIT]),
    .user_ok_i (pte_i[USER_BIT]),
    .req_i     (req),
    .grant_o   (grant_o),
    .denied_o  (denied),
    .cause_o   (cause_c)
  );

  pac_fault_reg u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .denied_i(denied),
    .cause_i (cause_c),
    .fault_o (fault_o),
    .cause_o (cause_o)
  );

  p_reserved_no_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reserved && req) |=> !fault_o);
  p_absent_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlate_en_o && req && !pte_i[PRESENT_BIT]) |=> (cause_o == CAUSE_ABSENT));
  p_user_page_any_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && pte_i[PRESENT_BIT] && pte_i[USER_BIT]) |-> grant_o);
  p_sup_only_user_deny_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlate_en_o && req && priv_i == PRIV_USER && !pte_i[USER_BIT]) |-> !grant_o);
endmodule

// File: tb/page_access_checker_tb.sv
module page_access_checker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv = 2'b00;
  logic [1:0]  ring = 2'b00;
  logic [3:0]  mode = 4'd0;
  logic [63:0] pte = '0;
  logic        rd = 1'b0, wr = 1'b0, ex = 1'b0;
  logic        xlate_en, grant, fault;
  logic [1:0]  cause;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_access_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .ring_i(ring), .mode_i(mode),
    .pte_i(pte), .rd_i(rd), .wr_i(wr), .ex_i(ex),
    .xlate_en_o(xlate_en), .grant_o(grant), .fault_o(fault), .cause_o(cause)
  );

  task automatic check(string req_tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  // Drive one access at negedge, check comb outputs, then the registered pulse.
  task automatic access(string req_tag, logic [1:0] p, logic [1:0] r, logic [3:0] m,
                        logic [63:0] e, logic [2:0] strb,
                        bit exp_x, bit exp_g, bit exp_f, logic [1:0] exp_c);
    @(negedge clk);
    priv = p; ring = r; mode = m; pte = e; {rd, wr, ex} = strb;
    #1;
    check(req_tag, "xlate_en", int'(xlate_en), int'(exp_x));
    check(req_tag, "grant", int'(grant), int'(exp_g));
    @(posedge clk);
    #1;
    {rd, wr, ex} = 3'b000;
    check(req_tag, "fault", int'(fault), int'(exp_f));
    check(req_tag, "cause", int'(cause), int'(exp_c));
  endtask

  localparam logic [63:0] E_USER = 64'h5; // present + user
  localparam logic [63:0] E_SUP  = 64'h1; // present, supervisor only
  localparam logic [63:0] E_BAD  = 64'h0; // absent, supervisor only

  task automatic t_reset;
    check("R9", "reset fault", int'(fault), 0);
    check("R9", "reset cause", int'(cause), 0);
  endtask

  task automatic t_mode_decode;
    access("R1", 2'b01, 2'b00, 4'd8, E_SUP, 3'b100, 1, 1, 0, 2'b00);
    access("R1", 2'b01, 2'b00, 4'd9, E_SUP, 3'b010, 1, 1, 0, 2'b00);
    access("R1", 2'b00, 2'b00, 4'd0, E_BAD, 3'b001, 0, 1, 0, 2'b00);
  endtask

  task automatic t_machine;
    access("R2", 2'b11, 2'b00, 4'd8, E_BAD, 3'b100, 0, 1, 0, 2'b00);
    access("R2", 2'b11, 2'b00, 4'd9, E_BAD, 3'b010, 0, 1, 0, 2'b00);
  endtask

  task automatic t_reserved;
    for (int m = 1; m < 16; m++) begin
      if (m == 8 || m == 9) continue;
      access("R3", 2'b00, 2'b00, 4'(m), E_BAD, 3'b100, 0, 1, 0, 2'b00);
    end
  endtask

  task automatic t_user_bit;
    access("R4", 2'b00, 2'b00, 4'd8, E_USER, 3'b100, 1, 1, 0, 2'b00);
    access("R4", 2'b01, 2'b00, 4'd9, E_USER, 3'b010, 1, 1, 0, 2'b00);
    access("R5", 2'b01, 2'b00, 4'd8, E_SUP, 3'b001, 1, 1, 0, 2'b00);
    access("R5", 2'b00, 2'b00, 4'd8, E_SUP, 3'b100, 1, 0, 1, 2'b01);
  endtask

  task automatic t_rings;
    for (int r = 0; r < 4; r++) begin
      bit ok = (r < 3);
      access("R6", 2'b10, 2'(r), 4'd9, E_SUP, 3'b100, 1, ok, !ok, ok ? 2'b00 : 2'b01);
    end
  endtask

  task automatic t_absent;
    access("R7", 2'b00, 2'b00, 4'd8, E_BAD, 3'b100, 1, 0, 1, 2'b10);
    access("R7", 2'b01, 2'b00, 4'd9, 64'h4, 3'b010, 1, 0, 1, 2'b10);
  endtask

  task automatic t_no_strobe;
    access("R8", 2'b01, 2'b00, 4'd8, E_USER, 3'b000, 1, 0, 0, 2'b00);
    access("R8", 2'b00, 2'b00, 4'd8, E_BAD, 3'b000, 1, 0, 0, 2'b00);
  endtask

  task automatic t_pulse;
    access("R9", 2'b00, 2'b00, 4'd8, E_SUP, 3'b010, 1, 0, 1, 2'b01);
    // idle cycle: pulse must have ended
    @(posedge clk);
    #1;
    check("R9", "pulse width", int'(fault), 0);
    check("R9", "cause idle", int'(cause), 0);
    access("R9", 2'b00, 2'b00, 4'd8, E_BAD, 3'b001, 1, 0, 1, 2'b10);
    access("R9", 2'b00, 2'b00, 4'd8, E_USER, 3'b001, 1, 1, 0, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_mode_decode();
    t_machine();
    t_reserved();
    t_user_bit();
    t_rings();
    t_absent();
    t_no_strobe();
    t_pulse();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule